// File: doc/BRIEF.md
# Erase-before-write page array

This block is an on-chip memory array that follows the rules of a small NAND flash. Storage is split into blocks, and each block holds a fixed number of pages. A page is one `DATA_W`-bit word. A client sends one command at a time over a valid/ready handshake: read a page, program a page, or erase a block. Every command ends with a single-cycle `cmd_done` pulse that carries a status code, the page word where one applies, and the wear count of the addressed block.

Programming can only pull bits down from 1 to 0. A page can be programmed only once between erases. The only way to bring bits back to 1 is to erase the whole block that holds the page, which also adds one to that block's wear counter.

The controller is a three-state machine:
- **S_IDLE** holds `cmd_ready` high. On an accepted command it takes one of two transitions:
  - *accept-good* to S_BUSY, after loading a timer with the latency of the operation.
  - *accept-reject* straight to S_REPORT, when the command fails its checks.
- **S_BUSY** counts the timer down. On the last cycle the operation commits to the storage, and the *commit* transition leads to S_REPORT.
- **S_REPORT** drives `cmd_done` for one cycle. The *release* transition then returns to S_IDLE.

Top module: `nand_array_model`

## Requirements
- R1: After reset every page of every block holds all ones, every wear count is zero, `cmd_ready` is high and `cmd_done` is low.
- R2: A read (`cmd_op` = 0) of an in-range page reports status 0, the stored page on `rsp_rdata`, and the block's wear count on `rsp_ecount`. It changes nothing.
- R3: A program (`cmd_op` = 1) of an unwritten page stores the bitwise AND of the old page and `cmd_wdata`, then marks the page written. It reports status 0, the resulting page on `rsp_rdata`, and the block's wear count.
- R4: A program of a page that has been programmed since the last erase of its block reports status 1. `rsp_rdata` and `rsp_ecount` read zero, and the page keeps its contents.
- R5: An erase (`cmd_op` = 2) sets every page of the addressed block to all ones and clears their written marks. Pages of other blocks are unchanged. The erase reports status 0 with `rsp_rdata` zero.
- R6: Each erase adds one to the wear count of the erased block only. The count saturates at 2^`CNT_W`-1. The erase report carries the new count.
- R7: A block address at or above `NUM_BLOCKS`, or a page address at or above `PAGES_PER_BLOCK` on a read or a program, reports status 2 and changes nothing. An erase ignores `cmd_page`.
- R8: A good command raises `cmd_done` `READ_CYC`, `PROG_CYC` or `ERASE_CYC` clock edges after its accepting edge, for a read, a program or an erase. A rejected command raises `cmd_done` right after its accepting edge.
- R9: The reserved operation code `cmd_op` = 3 reports status 3 and changes nothing.
- R10: `cmd_ready` is high only in S_IDLE. It stays low from the accepting edge through the cycle in which `cmd_done` is high. `cmd_done` never lasts more than one cycle.
- R11: While `cmd_done` is low, `rsp_status`, `rsp_rdata` and `rsp_ecount` are zero. On any nonzero status, `rsp_rdata` and `rsp_ecount` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_op | input | 2 | 0 read, 1 program, 2 erase, 3 reserved |
| cmd_blk | input | BLK_AW | Block address |
| cmd_page | input | PAGE_AW | Page address within the block |
| cmd_wdata | input | DATA_W | Program data |
| cmd_done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 0 ok, 1 page already written, 2 address out of range, 3 reserved op |
| rsp_rdata | output | DATA_W | Page word for reads and programs |
| rsp_ecount | output | CNT_W | Wear count of the addressed block |

## Verification
Counting from the edge that accepts a command, a read is due to report after `READ_CYC` edges, a program after `PROG_CYC` edges and an erase after `ERASE_CYC` edges. A rejected command reports right after the accepting edge. The driver stamps each accepted command with a cycle count taken just after that edge, together with the values a reference array predicts. The monitor samples `cmd_done` on falling edges and compares status, data and wear count, and it checks that the elapsed count equals the latency due for that command. The same monitor watches that `cmd_ready` stays low while a command is in flight and that `cmd_done` is never high on two falling edges in a row.

// File: rtl/nand_array_pkg.sv
package nand_array_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } nand_op_e;

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_REPROG = 2'd1,
        ST_RANGE  = 2'd2,
        ST_BADOP  = 2'd3
    } nand_status_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_BUSY   = 2'd1,
        S_REPORT = 2'd2
    } nand_state_e;

endpackage

// File: rtl/nand_cmd_fsm.sv
module nand_cmd_fsm
    import nand_array_pkg::*;
#(
    parameter int NUM_BLOCKS      = 8,
    parameter int PAGES_PER_BLOCK = 8,
    parameter int DATA_W          = 16,
    parameter int BLK_AW          = 4,
    parameter int PAGE_AW         = 4,
    parameter int READ_CYC        = 2,
    parameter int PROG_CYC        = 5,
    parameter int ERASE_CYC       = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [BLK_AW-1:0]  cmd_blk,
    input  logic [PAGE_AW-1:0] cmd_page,
    input  logic [DATA_W-1:0]  cmd_wdata,
    input  logic               page_written,
    output logic               cmd_ready,
    output logic               report,
    output logic               commit,
    output logic [1:0]         op_q,
    output logic [1:0]         status_q,
    output logic [BLK_AW-1:0]  blk_q,
    output logic [PAGE_AW-1:0] page_q,
    output logic [DATA_W-1:0]  wdata_q
);

    localparam int MAX_RP  = (READ_CYC > PROG_CYC) ? READ_CYC : PROG_CYC;
    localparam int MAX_CYC = (MAX_RP > ERASE_CYC) ? MAX_RP : ERASE_CYC;
    localparam int TMR_W   = $clog2(MAX_CYC) + 1;

    nand_state_e  state_q, state_d;
    nand_status_e verdict;
    logic [TMR_W-1:0] tmr_q;
    logic accept;

    function automatic logic [TMR_W-1:0] load_for(input logic [1:0] op);
        case (op)
            OP_READ:  return TMR_W'(READ_CYC - 1);
            OP_PROG:  return TMR_W'(PROG_CYC - 1);
            default:  return TMR_W'(ERASE_CYC - 1);
        endcase
    endfunction

    // Admission checks, in priority order
    always_comb begin
        verdict = ST_OK;
        if (cmd_op == OP_RSVD)
            verdict = ST_BADOP;
        else if (32'(cmd_blk) >= NUM_BLOCKS)
            verdict = ST_RANGE;
        else if (cmd_op != OP_ERASE && 32'(cmd_page) >= PAGES_PER_BLOCK)
            verdict = ST_RANGE;
        else if (cmd_op == OP_PROG && page_written)
            verdict = ST_REPROG;
    end

    assign accept = (state_q == S_IDLE) && cmd_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (cmd_valid) state_d = (verdict == ST_OK) ? S_BUSY : S_REPORT;
            S_BUSY:   if (tmr_q == '0) state_d = S_REPORT;
            S_REPORT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_ready = (state_q == S_IDLE);
        report    = (state_q == S_REPORT);
        commit    = (state_q == S_BUSY) && (tmr_q == '0);
    end

    // Command latch and busy timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= '0;
            status_q <= '0;
            blk_q    <= '0;
            page_q   <= '0;
            wdata_q  <= '0;
            tmr_q    <= '0;
        end else if (accept) begin
            op_q     <= cmd_op;
            status_q <= verdict;
            blk_q    <= cmd_blk;
            page_q   <= cmd_page;
            wdata_q  <= cmd_wdata;
            tmr_q    <= load_for(cmd_op);
        end else if (state_q == S_BUSY && tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
        end
    end

endmodule

// File: rtl/nand_page_store.sv
module nand_page_store #(
    parameter int NUM_BLOCKS      = 8,
    parameter int PAGES_PER_BLOCK = 8,
    parameter int DATA_W          = 16,
    parameter int BLK_AW          = 4,
    parameter int IDX_W           = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  flag_idx,
    output logic              flag_bit,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_page,
    input  logic              prog_en,
    input  logic [IDX_W-1:0]  prog_idx,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_en,
    input  logic [BLK_AW-1:0] erase_blk
);

    localparam int NPAGES = NUM_BLOCKS * PAGES_PER_BLOCK;

    logic [DATA_W-1:0] cell_bus [NPAGES];
    logic [NPAGES-1:0] flag_bus;

    for (genvar g = 0; g < NPAGES; g++) begin : g_page
        logic [DATA_W-1:0] cell_q;
        logic              written_q;
        logic              hit_prog;
        logic              hit_erase;

        assign hit_prog  = prog_en && (prog_idx == IDX_W'(g));
        assign hit_erase = erase_en && (erase_blk == BLK_AW'(g / PAGES_PER_BLOCK));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q    <= '1;
                written_q <= 1'b0;
            end else if (hit_erase) begin
                cell_q    <= '1;
                written_q <= 1'b0;
            end else if (hit_prog) begin
                cell_q    <= cell_q & prog_data;
                written_q <= 1'b1;
            end
        end

        assign cell_bus[g] = cell_q;
        assign flag_bus[g] = written_q;
    end

    always_comb begin
        rd_page  = '0;
        flag_bit = 1'b0;
        for (int i = 0; i < NPAGES; i++) begin
            if (rd_idx == IDX_W'(i))   rd_page  = cell_bus[i];
            if (flag_idx == IDX_W'(i)) flag_bit = flag_bus[i];
        end
    end

endmodule

// File: rtl/nand_wear_counters.sv
module nand_wear_counters #(
    parameter int NUM_BLOCKS = 8,
    parameter int BLK_AW     = 4,
    parameter int CNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_en,
    input  logic [BLK_AW-1:0] erase_blk,
    input  logic [BLK_AW-1:0] rd_blk,
    output logic [CNT_W-1:0]  rd_cnt
);

    logic [CNT_W-1:0] cnt_bus [NUM_BLOCKS];

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (erase_en && erase_blk == BLK_AW'(b) && cnt_q != '1)
                cnt_q <= cnt_q + 1'b1;
        end

        assign cnt_bus[b] = cnt_q;
    end

    always_comb begin
        rd_cnt = '0;
        for (int i = 0; i < NUM_BLOCKS; i++)
            if (rd_blk == BLK_AW'(i)) rd_cnt = cnt_bus[i];
    end

endmodule

// File: rtl/nand_array_model.sv
module nand_array_model
    import nand_array_pkg::*;
#(
    parameter int NUM_BLOCKS      = 8,
    parameter int PAGES_PER_BLOCK = 8,
    parameter int DATA_W          = 16,
    parameter int BLK_AW          = 4,
    parameter int PAGE_AW         = 4,
    parameter int CNT_W           = 8,
    parameter int READ_CYC        = 2,
    parameter int PROG_CYC        = 5,
    parameter int ERASE_CYC       = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [1:0]         cmd_op,
    input  logic [BLK_AW-1:0]  cmd_blk,
    input  logic [PAGE_AW-1:0] cmd_page,
    input  logic [DATA_W-1:0]  cmd_wdata,
    output logic               cmd_done,
    output logic [1:0]         rsp_status,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [CNT_W-1:0]   rsp_ecount
);

    localparam int NPAGES = NUM_BLOCKS * PAGES_PER_BLOCK;
    localparam int IDX_W  = (NPAGES > 1) ? $clog2(NPAGES) : 1;

    logic               report, commit, page_written;
    logic [1:0]         op_q, status_q;
    logic [BLK_AW-1:0]  blk_q;
    logic [PAGE_AW-1:0] page_q;
    logic [DATA_W-1:0]  wdata_q, page_word;
    logic [CNT_W-1:0]   wear_cnt;
    logic [IDX_W-1:0]   cmd_idx, lat_idx;
    logic               do_prog, do_erase;

    function automatic logic [IDX_W-1:0] page_index(input logic [BLK_AW-1:0] b,
                                                    input logic [PAGE_AW-1:0] p);
        int unsigned v;
        v = 32'(b) * PAGES_PER_BLOCK + 32'(p);
        if (v >= NPAGES) v = 0;
        return IDX_W'(v);
    endfunction

    assign cmd_idx  = page_index(cmd_blk, cmd_page);
    assign lat_idx  = page_index(blk_q, page_q);
    assign do_prog  = commit && (op_q == OP_PROG);
    assign do_erase = commit && (op_q == OP_ERASE);

    nand_cmd_fsm #(
        .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK), .DATA_W(DATA_W),
        .BLK_AW(BLK_AW), .PAGE_AW(PAGE_AW),
        .READ_CYC(READ_CYC), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_blk(cmd_blk), .cmd_page(cmd_page), .cmd_wdata(cmd_wdata),
        .page_written(page_written), .cmd_ready(cmd_ready), .report(report),
        .commit(commit), .op_q(op_q), .status_q(status_q), .blk_q(blk_q),
        .page_q(page_q), .wdata_q(wdata_q)
    );

    nand_page_store #(
        .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
        .DATA_W(DATA_W), .BLK_AW(BLK_AW), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .flag_idx(cmd_idx), .flag_bit(page_written),
        .rd_idx(lat_idx), .rd_page(page_word), .prog_en(do_prog), .prog_idx(lat_idx),
        .prog_data(wdata_q), .erase_en(do_erase), .erase_blk(blk_q)
    );

    nand_wear_counters #(
        .NUM_BLOCKS(NUM_BLOCKS), .BLK_AW(BLK_AW), .CNT_W(CNT_W)
    ) u_wear (
        .clk(clk), .rst_n(rst_n), .erase_en(do_erase), .erase_blk(blk_q),
        .rd_blk(blk_q), .rd_cnt(wear_cnt)
    );

    // Response outputs, valid only in the report cycle
    always_comb begin
        cmd_done   = report;
        rsp_status = '0;
        rsp_rdata  = '0;
        rsp_ecount = '0;
        if (report) begin
            rsp_status = status_q;
            if (status_q == ST_OK) begin
                rsp_ecount = wear_cnt;
                if (op_q != OP_ERASE) rsp_rdata = page_word;
            end
        end
    end

endmodule

// File: rtl/nand_array_checker.sv
module nand_array_checker #(
    parameter int NUM_BLOCKS = 8,
    parameter int BLK_AW     = 4,
    parameter int DATA_W     = 16,
    parameter int CNT_W      = 8,
    parameter int READ_CYC   = 2,
    parameter int PROG_CYC   = 5,
    parameter int ERASE_CYC  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [1:0]        cmd_op,
    input logic [BLK_AW-1:0] cmd_blk,
    input logic [DATA_W-1:0] cmd_wdata,
    input logic              cmd_done,
    input logic [1:0]        rsp_status,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [CNT_W-1:0]  rsp_ecount
);

    logic              acc;
    logic [15:0]       since_acc;
    logic [1:0]        op_seen;
    logic [DATA_W-1:0] wdata_seen;

    assign acc = cmd_valid && cmd_ready;

    function automatic logic [15:0] due(input logic [1:0] op);
        case (op)
            2'd0:    return 16'(READ_CYC + 1);
            2'd1:    return 16'(PROG_CYC + 1);
            default: return 16'(ERASE_CYC + 1);
        endcase
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_acc  <= '0;
            op_seen    <= '0;
            wdata_seen <= '0;
        end else if (acc) begin
            since_acc  <= 16'd1;
            op_seen    <= cmd_op;
            wdata_seen <= cmd_wdata;
        end else if (since_acc != '1) begin
            since_acc <= since_acc + 1'b1;
        end
    end

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    a_r10_ready_low_done: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> !cmd_ready);

    a_r10_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !cmd_ready);

    a_r7_range_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op != 2'd3 && 32'(cmd_blk) >= NUM_BLOCKS) |=> (cmd_done && rsp_status == 2'd2));

    a_r9_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 2'd3) |=> (cmd_done && rsp_status == 2'd3));

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && rsp_status == 2'd0) |-> (since_acc == due(op_seen)));

    a_r3_prog_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && rsp_status == 2'd0 && op_seen == 2'd1) |-> ((rsp_rdata & ~wdata_seen) == '0));

    a_r6_erase_counted: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && rsp_status == 2'd0 && op_seen == 2'd2) |-> (rsp_ecount != '0));

    a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_done |-> (rsp_status == 2'd0 && rsp_rdata == '0 && rsp_ecount == '0));

endmodule

bind nand_array_model nand_array_checker #(
    .NUM_BLOCKS(NUM_BLOCKS), .BLK_AW(BLK_AW), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .READ_CYC(READ_CYC), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
) u_checker (.*);

// File: tb/nand_array_model_bench.sv
module nand_array_model_bench;

    localparam int NB = 8, PG = 8, DW = 16, BAW = 4, PAW = 4, CW = 8;
    localparam int RC = 2, PC = 5, EC = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic           cmd_ready;
    logic [1:0]     cmd_op = '0;
    logic [BAW-1:0] cmd_blk = '0;
    logic [PAW-1:0] cmd_page = '0;
    logic [DW-1:0]  cmd_wdata = '0;
    logic           cmd_done;
    logic [1:0]     rsp_status;
    logic [DW-1:0]  rsp_rdata;
    logic [CW-1:0]  rsp_ecount;

    always #10 clk = ~clk;

    nand_array_model #(
        .NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PG), .DATA_W(DW), .BLK_AW(BAW),
        .PAGE_AW(PAW), .CNT_W(CW), .READ_CYC(RC), .PROG_CYC(PC), .ERASE_CYC(EC)
    ) u_nand_array_model (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_blk(cmd_blk), .cmd_page(cmd_page), .cmd_wdata(cmd_wdata),
        .cmd_done(cmd_done), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
        .rsp_ecount(rsp_ecount)
    );

    typedef struct {
        string         req;
        logic [1:0]    st;
        logic [DW-1:0] rd;
        logic [CW-1:0] ec;
        int            lat;
        int            acc;
    } exp_t;

    exp_t          sb[$];
    logic [DW-1:0] mdl [NB][PG];
    bit            mflag [NB][PG];
    int            mcnt [NB];
    int            checks = 0, fails = 0, cyc = 0, busy_err = 0;
    bit            prev_done = 1'b0, reported = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Driver: predict from the reference array, then hand the command over
    task automatic issue(input int op, input int b, input int p,
                         input logic [DW-1:0] d, input string req);
        exp_t e;
        e.req = req; e.rd = '0; e.ec = '0; e.lat = 0;
        if (op == 3)                          e.st = 2'd3;
        else if (b >= NB)                     e.st = 2'd2;
        else if (op != 2 && p >= PG)          e.st = 2'd2;
        else if (op == 1 && mflag[b][p])      e.st = 2'd1;
        else                                  e.st = 2'd0;
        if (e.st == 2'd0) begin
            case (op)
                0: begin e.rd = mdl[b][p]; e.ec = CW'(mcnt[b]); e.lat = RC; end
                1: begin
                    mdl[b][p] = mdl[b][p] & d; mflag[b][p] = 1'b1;
                    e.rd = mdl[b][p]; e.ec = CW'(mcnt[b]); e.lat = PC;
                end
                default: begin
                    for (int i = 0; i < PG; i++) begin mdl[b][i] = '1; mflag[b][i] = 1'b0; end
                    if (mcnt[b] < 255) mcnt[b]++;
                    e.ec = CW'(mcnt[b]); e.lat = EC;
                end
            endcase
        end
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_blk = BAW'(b);
        cmd_page = PAW'(p); cmd_wdata = d;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        e.acc = cyc;
        sb.push_back(e);
    endtask

    // Monitor: compare each report against the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb.size() != 0 && cmd_ready && !cmd_done) busy_err++;
            if (prev_done && cmd_done) busy_err++;
            prev_done = cmd_done;
            if (cmd_done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10", "unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(rsp_status == e.st, e.req, "status", 32'(rsp_status), 32'(e.st));
                    check(rsp_rdata == e.rd, e.req, "rdata", 32'(rsp_rdata), 32'(e.rd));
                    check(rsp_ecount == e.ec, e.req, "ecount", 32'(rsp_ecount), 32'(e.ec));
                    check(cyc - e.acc == e.lat, "R8", "latency", 32'(cyc - e.acc), 32'(e.lat));
                    check(!cmd_ready, "R10", "ready during done", 32'(cmd_ready), 32'd0);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", "run hung", 32'd0, 32'd1);
        summary();
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            mcnt[b] = 0;
            for (int p = 0; p < PG; p++) begin mdl[b][p] = '1; mflag[b][p] = 1'b0; end
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(cmd_ready == 1'b1, "R1", "ready after reset", 32'(cmd_ready), 32'd1);
        check(cmd_done == 1'b0, "R1", "done after reset", 32'(cmd_done), 32'd0);
        check(rsp_status == 2'd0 && rsp_rdata == '0 && rsp_ecount == '0, "R11",
              "idle outputs", 32'(rsp_rdata), 32'd0);

        issue(0, 0, 0, '0, "R1");
        issue(0, 7, 7, '0, "R1");
        issue(1, 0, 0, 16'hA5F0, "R3");
        issue(0, 0, 0, '0, "R2");
        issue(1, 0, 0, 16'h0F0F, "R4");
        issue(0, 0, 0, '0, "R4");
        issue(1, 0, 1, 16'h1234, "R3");
        issue(1, 1, 7, 16'h0000, "R3");
        issue(2, 0, 0, '0, "R5");
        issue(0, 0, 0, '0, "R5");
        issue(0, 0, 1, '0, "R5");
        issue(0, 1, 7, '0, "R5");
        issue(1, 0, 0, 16'h00FF, "R5");
        issue(1, 0, 0, 16'h0F0F, "R4");
        issue(2, 0, 3, '0, "R6");
        issue(2, 0, 9, '0, "R7");
        issue(2, 7, 0, '0, "R6");
        issue(0, 0, 0, '0, "R6");
        issue(0, 8, 0, '0, "R7");
        issue(1, 9, 0, 16'h0000, "R7");
        issue(1, 1, 8, 16'h0000, "R7");
        issue(0, 2, 0, '0, "R7");
        issue(0, 1, 0, '0, "R7");
        issue(2, 12, 0, '0, "R7");
        issue(0, 4, 0, '0, "R7");
        issue(3, 3, 3, 16'h0000, "R9");
        issue(0, 3, 3, '0, "R9");
        issue(1, 6, 2, 16'hFFFF, "R3");
        issue(1, 6, 3, 16'h8001, "R3");
        issue(0, 6, 3, '0, "R2");
        for (int k = 0; k < 258; k++) issue(2, 5, 0, '0, "R6");
        issue(0, 5, 0, '0, "R6");
        issue(0, 4, 0, '0, "R6");

        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(busy_err == 0, "R10", "ready or done violations", 32'(busy_err), 32'd0);
        summary();
    end

endmodule